// File: doc/BRIEF.md
# Scheduled Square-Wave Pin With Edge Capture

This block owns one bidirectional clock pin of a time-keeping subsystem. In output mode it produces a square wave with a 50% duty cycle. The wave is locked to a free-running tick counter that the block receives as an input. Software loads an absolute start tick and a half-period in ticks, then issues a start strobe. The first toggle lands on the programmed tick. Every later toggle is scheduled relative to the previous scheduled tick rather than to the moment it was seen, so the phase never drifts. With an 8 ns tick, the output frequency is 1e9 / (half-period × 16) Hz.

A direction input turns the same pin into a capture input. Every level change on the pin is first passed through a synchronizer. Each change, rising or falling, then copies the counter into a single timestamp register. There is no queue and no notification, so a later edge simply replaces the earlier value. While the pin is an input, the wave generator is held off and its drive is released.

Top module: `sched_clk_pin`

## Requirements
- R1: While rst_n is low, pin_out is 0, sync_ts is 0 and the generator is disarmed; pin_oe is 1 whenever dir_in is 0 and 0 whenever dir_in is 1.
- R2: A start_req is accepted only if start_time is strictly greater than the time_now seen in the same cycle. A start_req with start_time equal to or less than time_now changes nothing: the pin stays low and does not toggle.
- R3: After a start is accepted, the pin goes from 0 to 1 in the first clock cycle whose time_now is equal to or greater than start_time, including a counter that jumps past it.
- R4: Each later toggle happens in the first cycle whose time_now reaches the previous scheduled toggle tick plus half_period. A counter advancing by one per cycle therefore sees toggles at start_time + k × half_period.
- R5: stop_req forces pin_out to 0 one cycle later and disarms the generator. If stop_req and start_req arrive together, stop_req wins.
- R6: With dir_in = 1, pin_out is held at 0, pin_oe is 0 and start_req is ignored. Changing dir_in disarms the generator.
- R7: With dir_in = 1, each change of pin_in (both rising and falling) loads sync_ts with time_now. Capture happens at the third rising clock edge after pin_in changes, counting the first edge that sees the new level. No edge can be selected or masked.
- R8: sync_ts is a single register: a newer captured edge overwrites it. Changes of pin_in while dir_in = 0 leave it unchanged.
- R9: half_period is 32 bits wide and is zero-extended into the 64-bit schedule, so a half-period of 0xFFFF_FFFF ticks leaves the pin steady for that many ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current value of the tick counter |
| start_time | input | 64 | Absolute tick of the first toggle |
| half_period | input | 32 | Ticks between consecutive toggles |
| start_req | input | 1 | One-cycle start command |
| stop_req | input | 1 | One-cycle stop command |
| dir_in | input | 1 | 1 = pin is a capture input, 0 = pin is the wave output |
| pin_in | input | 1 | Asynchronous level sensed on the pin |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Drive enable for the pin |
| sync_ts | output | 64 | Counter value at the most recent captured edge |

## Verification
A wrong schedule register shows at pin_out on the first toggle after the fault: the toggle either lands on the wrong tick or repeats every cycle. Counting the ticks between toggles exposes an accumulating error within two half-periods. A stale armed state shows as a toggle after a stop or in capture mode, one cycle after the counter passes the stale tick. A broken synchronizer or edge detector changes the tick stored in sync_ts by one or more cycles, so the fault appears at the first captured edge.

// File: rtl/sched_clk_pin_pkg.sv
package sched_clk_pin_pkg;

   typedef enum logic {
      GEN_IDLE  = 1'b0,
      GEN_ARMED = 1'b1
   } gen_state_e;

   typedef enum logic {
      PIN_DRIVE   = 1'b0,
      PIN_CAPTURE = 1'b1
   } pin_dir_e;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];

endmodule

// File: rtl/scp_capture.sv
module scp_capture #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              level_s,
   input  logic [TIME_W-1:0] time_now,
   output logic [TIME_W-1:0] ts_out
);

   logic level_q;
   logic any_edge;

   assign any_edge = level_s ^ level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         ts_out  <= '0;
      end else begin
         level_q <= level_s;
         if (cap_en && any_edge) ts_out <= time_now;
      end
   end

endmodule

// File: rtl/scp_wavegen.sv
module scp_wavegen
   import sched_clk_pin_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_now,
   input  logic [TIME_W-1:0] start_time,
   input  logic [HALF_W-1:0] half_period,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              hold_off,
   output logic              wave_out
);

   gen_state_e        state;
   logic [TIME_W-1:0] due_tick;
   logic [TIME_W-1:0] step_ext;
   logic              start_ok;
   logic              due_now;

   assign step_ext = TIME_W'(half_period);
   assign start_ok = start_req && (start_time > time_now);
   assign due_now  = (state == GEN_ARMED) && (time_now >= due_tick);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= GEN_IDLE;
         due_tick <= '0;
         wave_out <= 1'b0;
      end else if (stop_req || hold_off) begin
         state    <= GEN_IDLE;
         wave_out <= 1'b0;
      end else if (start_ok) begin
         state    <= GEN_ARMED;
         due_tick <= start_time;
         wave_out <= 1'b0;
      end else if (due_now) begin
         wave_out <= ~wave_out;
         due_tick <= due_tick + step_ext;
      end
   end

endmodule

// File: rtl/sched_clk_pin.sv
module sched_clk_pin
   import sched_clk_pin_pkg::*;
#(
   parameter int TIME_W      = 64,
   parameter int HALF_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_now,
   input  logic [TIME_W-1:0] start_time,
   input  logic [HALF_W-1:0] half_period,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              dir_in,
   input  logic              pin_in,
   output logic              pin_out,
   output logic              pin_oe,
   output logic [TIME_W-1:0] sync_ts
);

   generate
      if (HALF_W > TIME_W) begin : g_bad_width
         $error("sched_clk_pin: HALF_W must not exceed TIME_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sched_clk_pin: SYNC_STAGES must be at least 2");
      end
   endgenerate

   pin_dir_e dir_mode;
   logic     pin_sync;
   logic     capture_on;

   assign dir_mode   = pin_dir_e'(dir_in);
   assign capture_on = (dir_mode == PIN_CAPTURE);
   assign pin_oe     = !capture_on;

   scp_wavegen #(
      .TIME_W (TIME_W),
      .HALF_W (HALF_W)
   ) i_wavegen (
      .clk         (clk),
      .rst_n       (rst_n),
      .time_now    (time_now),
      .start_time  (start_time),
      .half_period (half_period),
      .start_req   (start_req),
      .stop_req    (stop_req),
      .hold_off    (capture_on),
      .wave_out    (pin_out)
   );

   scp_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (pin_sync)
   );

   scp_capture #(
      .TIME_W (TIME_W)
   ) i_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (capture_on),
      .level_s  (pin_sync),
      .time_now (time_now),
      .ts_out   (sync_ts)
   );

endmodule

// File: rtl/sched_clk_pin_chk.sv
module sched_clk_pin_chk #(
   parameter int TIME_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_req,
   input logic              dir_in,
   input logic              pin_out,
   input logic [TIME_W-1:0] sync_ts
);

   logic past_ok = 1'b0;
   logic in_rst_q = 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   always_ff @(posedge clk) in_rst_q <= !rst_n;

   // R1: reset leaves pin low and timestamp cleared
   assert_reset_state_R1: assert property (@(posedge clk)
      in_rst_q |-> (!pin_out && sync_ts == '0));

   // R5: a stop drives the pin low on the next cycle
   assert_stop_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(stop_req)) |-> !pin_out);

   // R6: capture mode keeps the generator silent
   assert_capture_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(dir_in)) |-> !pin_out);

   // R8: no timestamp update while the pin is an output
   assert_no_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(dir_in)) |-> $stable(sync_ts));

endmodule

bind sched_clk_pin sched_clk_pin_chk #(.TIME_W(TIME_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .stop_req (stop_req),
   .dir_in   (dir_in),
   .pin_out  (pin_out),
   .sync_ts  (sync_ts)
);

// File: tb/test_sched_clk_pin.sv
module test_sched_clk_pin;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] tc;
   logic [63:0] start_time;
   logic [31:0] half_period;
   logic        start_req, stop_req, dir_in, pin_in;
   logic        pin_out, pin_oe;
   logic [63:0] sync_ts;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [63:0] obs_tc;
   logic        obs_pin;

   always #2 clk = ~clk;

   sched_clk_pin i_sched_clk_pin (
      .clk         (clk),
      .rst_n       (rst_n),
      .time_now    (tc),
      .start_time  (start_time),
      .half_period (half_period),
      .start_req   (start_req),
      .stop_req    (stop_req),
      .dir_in      (dir_in),
      .pin_in      (pin_in),
      .pin_out     (pin_out),
      .pin_oe      (pin_oe),
      .sync_ts     (sync_ts)
   );

   // stimulus table: start offset, half period, expected toggle count
   localparam int NV = 5;
   localparam int unsigned V_OFF [NV]  = '{5, 1, 0, 20, 2};
   localparam int unsigned V_HALF[NV]  = '{3, 4, 3, 1, 7};
   localparam int unsigned V_NTOG[NV]  = '{4, 4, 0, 4, 4};

   task automatic tick();
      @(negedge clk);
      obs_tc  = tc;
      obs_pin = pin_out;
      tc      = tc + 64'd1;
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_stop();
      stop_req = 1'b1;
      tick();
      stop_req = 1'b0;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] s, hold, x;
      int nt;
      bit hi_seen;

      rst_n = 1'b0; tc = 64'd100; start_time = '0; half_period = '0;
      start_req = 0; stop_req = 0; dir_in = 0; pin_in = 0;
      repeat (3) tick();
      chk(pin_out == 1'b0, "R1 pin low in reset", pin_out, 0);
      chk(sync_ts == 64'd0, "R1 sync_ts cleared", sync_ts, 0);
      chk(pin_oe == 1'b1, "R1 oe with dir 0", pin_oe, 1);
      rst_n = 1'b1;
      tick();

      // table walk: R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         do_stop();
         s = tc + 64'(V_OFF[i]);
         start_time = s; half_period = V_HALF[i]; start_req = 1'b1;
         tick();
         start_req = 1'b0;
         nt = 0;
         for (int k = 0; k < int'(V_OFF[i] + 3 * V_HALF[i]); k++) begin
            logic prev;
            prev = pin_out;
            tick();
            if (obs_pin != prev) begin
               chk(obs_tc == s + 64'(nt) * 64'(V_HALF[i]), "R4 toggle tick",
                   obs_tc, s + 64'(nt) * 64'(V_HALF[i]));
               chk(obs_pin == ((nt % 2) == 0), "R3 toggle level", obs_pin,
                   64'((nt % 2) == 0));
               nt++;
            end
         end
         chk(nt == int'(V_NTOG[i]), "R2 toggle count", nt, V_NTOG[i]);
      end
      do_stop();
      chk(pin_out == 1'b0, "R5 low after stop", pin_out, 0);

      // R2: start time in the past
      start_time = tc - 64'd1; half_period = 2; start_req = 1;
      tick(); start_req = 0;
      hi_seen = 0;
      repeat (20) begin tick(); if (obs_pin) hi_seen = 1; end
      chk(!hi_seen, "R2 past start ignored", hi_seen, 0);

      // R5: stop wins over start
      start_time = tc + 64'd3; half_period = 2; start_req = 1; stop_req = 1;
      tick(); start_req = 0; stop_req = 0;
      hi_seen = 0;
      repeat (12) begin tick(); if (obs_pin) hi_seen = 1; end
      chk(!hi_seen, "R5 stop beats start", hi_seen, 0);

      // R5: stop in the middle of a run
      start_time = tc + 64'd2; half_period = 6; start_req = 1;
      tick(); start_req = 0;
      repeat (4) tick();
      chk(pin_out == 1'b1, "R3 high before stop", pin_out, 1);
      stop_req = 1; tick(); stop_req = 0; tick();
      chk(obs_pin == 1'b0, "R5 stop forces low", obs_pin, 0);
      hi_seen = 0;
      repeat (20) begin tick(); if (obs_pin) hi_seen = 1; end
      chk(!hi_seen, "R5 disarmed after stop", hi_seen, 0);

      // R3: counter jumps past start; R4 phase kept
      s = tc + 64'd10;
      start_time = s; half_period = 100; start_req = 1;
      tick(); start_req = 0;
      tick();
      tc = s + 64'd5;
      tick();
      chk(obs_pin == 1'b1 && obs_tc == s + 64'd5, "R3 toggle on pass",
          {obs_pin, obs_tc[62:0]}, {1'b1, s[62:0] + 63'd5});
      for (int k = 0; k < 200; k++) begin
         tick();
         if (!obs_pin) break;
      end
      chk(obs_tc == s + 64'd100, "R4 no phase drift", obs_tc, s + 64'd100);
      do_stop();

      // R9: maximum half period
      start_time = tc + 64'd2; half_period = 32'hFFFF_FFFF; start_req = 1;
      tick(); start_req = 0;
      repeat (3) tick();
      hold = 0;
      repeat (50) begin tick(); if (!obs_pin) hold = 1; end
      chk(hold == 0 && pin_out == 1'b1, "R9 wide half period", hold, 0);
      do_stop();

      // R6: capture mode
      dir_in = 1; tick();
      chk(pin_oe == 1'b0, "R6 oe released", pin_oe, 0);
      start_time = tc + 64'd2; half_period = 2; start_req = 1;
      tick(); start_req = 0;
      hi_seen = 0;
      repeat (10) begin tick(); if (obs_pin) hi_seen = 1; end
      chk(!hi_seen, "R6 start ignored in capture", hi_seen, 0);

      // R7: rising then falling capture
      pin_in = 1; x = tc;
      repeat (3) tick();
      chk(sync_ts == x + 64'd2, "R7 rising capture", sync_ts, x + 64'd2);
      repeat (4) tick();
      pin_in = 0; x = tc;
      repeat (3) tick();
      chk(sync_ts == x + 64'd2, "R8 falling overwrites", sync_ts, x + 64'd2);

      // R8: output mode ignores pin edges
      dir_in = 0; tick();
      chk(pin_oe == 1'b1, "R6 oe back on", pin_oe, 1);
      hold = sync_ts;
      pin_in = 1;
      repeat (6) tick();
      chk(sync_ts == hold, "R8 no capture in output mode", sync_ts, hold);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule